// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block takes eight edge-triggered interrupt request lines, ranks them by fixed priority, and signals the processor through a single interrupt output. Software talks to it through a byte-wide register port with one address bit. Address 0 takes commands and returns a status register. Address 1 takes the mask and the setup words and returns the mask. On a two-pulse acknowledge, the winning request moves into service and the block returns a vector byte built from a programmed base and the line number.

Two copies can be chained. The slave's interrupt output feeds one request line of the master. When the master grants that line, it drives the line number on a 3-bit cascade bus between the two acknowledge pulses. The slave whose identity matches then commits its own winner and supplies the vector. The block must be set up with a fixed four-byte sequence before it reacts to any request. It supports specific end-of-interrupt commands and an automatic end-of-interrupt mode. If the winning request vanishes before the acknowledge, it answers with the lowest-priority line's vector.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the interrupt output is low, and no rising request is recorded until setup completes. A write to address 1 before setup still loads the mask.
- R2: Setup begins when byte 0x11 is written to address 0. The next three writes to address 1 are taken, in order, as the vector base, the cascade word and the mode word. A request line that rises before the third of these writes is not recorded.
- R3: The returned vector has the upper five bits of the base word in bits 7:3 and the line number in bits 2:0.
- R4: Outside setup, a write to address 1 loads the mask (bit n belongs to line n). A set mask bit stops its line from raising the interrupt output but keeps the request. A read of address 1 returns the mask.
- R5: Command 0x0A selects the request register and command 0x0B selects the in-service register for later reads of address 0. The choice holds until it is changed, and setup resets it to the request register. Read data appears on the cycle after the read strobe.
- R6: Priority is fixed, with line 0 highest. A rising input sets its request bit, and a low input or an acknowledge clears it. A pending unmasked line raises the interrupt output only if no in-service bit at its own or higher priority is set.
- R7: The first acknowledge pulse commits the winner: its request bit clears and its in-service bit sets. The vector is presented for exactly one cycle, with the valid flag, on the cycle after the second pulse.
- R8: Command 0x60+n clears in-service bit n and no other bit.
- R9: Mode word 0x03 selects automatic end-of-interrupt, where no in-service bit is set by an acknowledge. Mode word 0x01 selects the normal behaviour.
- R10: If no line is grantable at the commit pulse, the vector of line 7 is returned and no in-service bit is set, even when line 7 is masked.
- R11: On a master (slave-select input low), the cascade word marks the lines that have a slave. When such a line wins, the master sets its in-service bit and drives the cascade enable and the line number from the first pulse to the second pulse. It presents no vector of its own.
- R12: A slave takes bits 2:0 of the cascade word as its identity. It commits its winner and presents its vector after the second pulse only when the cascade enable is high and the cascade number matches its identity. Otherwise it stays silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_slave | input | 1 | Strap: high makes this copy a slave |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address (0 command/status, 1 mask/setup) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor or master |
| ack | input | 1 | Acknowledge pulse, issued in pairs |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | One-cycle vector valid |
| cas_in | input | 3 | Cascade line number from the master |
| cas_en_in | input | 1 | Cascade number valid from the master |
| cas_out | output | 3 | Cascade line number driven by a master |
| cas_oe | output | 1 | Cascade number valid driven by a master |

## Verification
A rising request is recorded on the first clock edge and reaches the interrupt output on the second. A slave's request therefore reaches the master's output four edges after the slave's line rises. Register writes act on the edge that samples them, and the interrupt output follows one edge later. Read data and vectors appear on the edge after the read strobe or the second acknowledge. The cascade outputs change on the edge of the first pulse. Every check samples half a cycle after these edges: the interrupt output is checked after two edges (four for the chained case), and the vector, cascade and read values are checked at the falling edge right after the edge on which they are due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned LINES  = 8;

  localparam logic [7:0] CMD_INIT    = 8'h11;
  localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
  localparam logic [4:0] CMD_EOI_TAG = 5'b01100;

  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_RUN
  } cfg_state_e;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int N  = LINES,
  parameter int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              running,
  output logic              init_start,
  output logic [BYTE_W-IW-1:0] base,
  output logic [BYTE_W-1:0] casc,
  output logic              aeoi,
  output logic [N-1:0]      mask,
  output logic              sel_svc,
  output logic              eoi_go,
  output logic [IW-1:0]     eoi_idx
);
  cfg_state_e state;
  logic cmd_wr, dat_wr;

  assign cmd_wr     = wr_en & ~addr;
  assign dat_wr     = wr_en & addr;
  assign running    = (state == CFG_RUN);
  assign init_start = cmd_wr && (wdata == CMD_INIT);
  assign eoi_go     = cmd_wr && running && (wdata[BYTE_W-1:IW] == CMD_EOI_TAG);
  assign eoi_idx    = wdata[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CFG_IDLE;
      base    <= '0;
      casc    <= '0;
      aeoi    <= 1'b0;
      mask    <= '1;
      sel_svc <= 1'b0;
    end else if (init_start) begin
      state   <= CFG_BASE;
      sel_svc <= 1'b0;
      aeoi    <= 1'b0;
    end else if (dat_wr) begin
      case (state)
        CFG_BASE: begin
          base  <= wdata[BYTE_W-1:IW];
          state <= CFG_CASC;
        end
        CFG_CASC: begin
          casc  <= wdata;
          state <= CFG_MODE;
        end
        CFG_MODE: begin
          aeoi  <= wdata[1];
          state <= CFG_RUN;
        end
        default: mask <= wdata[N-1:0];
      endcase
    end else if (cmd_wr && running) begin
      if (wdata == CMD_SEL_REQ)      sel_svc <= 1'b0;
      else if (wdata == CMD_SEL_SVC) sel_svc <= 1'b1;
    end
  end

  // R2: the cascade word slot is reached only from the base word slot
  p_init_order_r2: assert property (@(posedge clk) disable iff (rst)
    (state == CFG_CASC) |-> ($past(state) == CFG_BASE || $past(state) == CFG_CASC));

  // R2: the run state is reached only through the mode word slot
  p_run_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> ($past(state) == CFG_MODE));
endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         clear_all,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= lines;
      if (clear_all || !enable) irr <= '0;
      else                      irr <= (irr & lines & ~clr) | (lines & ~prev_q);
    end
  end

  // R6: a recorded request never outlives its input being low
  p_irr_needs_line_r6: assert property (@(posedge clk) disable iff (rst)
    ((irr & ~$past(lines)) == '0));
endmodule

// File: rtl/irqc_prio_resolve.sv
module irqc_prio_resolve #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  isr,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic          blocked
);
  logic [N-1:0] svc_upto;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_upto
      assign svc_upto[g] = |isr[g:0];
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign blocked = svc_upto[idx];
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_LINES = LINES,
  localparam int IW     = $clog2(N_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_slave,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic              int_out,
  input  logic              ack,
  output logic [BYTE_W-1:0] vec_out,
  output logic              vec_valid,
  input  logic [IW-1:0]     cas_in,
  input  logic              cas_en_in,
  output logic [IW-1:0]     cas_out,
  output logic              cas_oe
);
  logic                 running, init_start, aeoi, sel_svc, eoi_go;
  logic [BYTE_W-IW-1:0] base;
  logic [BYTE_W-1:0]    casc;
  logic [N_LINES-1:0]   mask, irr, isr, irr_clr, eoi_mask;
  logic [IW-1:0]        eoi_idx, win_idx, idx_eff;
  logic                 found, blocked, grant;
  logic                 phase_q, own_q, commit_go, commit_real, svc_set, cascaded;
  logic [BYTE_W-1:0]    vec_hold;

  irqc_cfg #(.N(N_LINES), .IW(IW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .running(running), .init_start(init_start), .base(base), .casc(casc),
    .aeoi(aeoi), .mask(mask), .sel_svc(sel_svc), .eoi_go(eoi_go), .eoi_idx(eoi_idx)
  );

  irqc_req_latch #(.N(N_LINES)) u_req (
    .clk(clk), .rst(rst), .enable(running), .clear_all(init_start),
    .lines(irq_in), .clr(irr_clr), .irr(irr)
  );

  irqc_prio_resolve #(.N(N_LINES), .IW(IW)) u_prio (
    .pend(irr & ~mask), .isr(isr), .found(found), .idx(win_idx), .blocked(blocked)
  );

  assign grant       = found && !blocked;
  assign commit_go   = running && ack &&
                       (is_slave ? (phase_q && cas_en_in && (cas_in == casc[IW-1:0])) : !phase_q);
  assign commit_real = commit_go && grant;
  assign idx_eff     = grant ? win_idx : {IW{1'b1}};
  assign irr_clr     = commit_real ? (N_LINES'(1) << win_idx) : '0;
  assign svc_set     = commit_real && !aeoi;
  assign cascaded    = !is_slave && grant && casc[win_idx];
  assign eoi_mask    = eoi_go ? (N_LINES'(1) << eoi_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr       <= '0;
      phase_q   <= 1'b0;
      own_q     <= 1'b0;
      vec_hold  <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      cas_out   <= '0;
      cas_oe    <= 1'b0;
      int_out   <= 1'b0;
      rdata     <= '0;
    end else begin
      vec_valid <= 1'b0;
      int_out   <= running && grant;
      if (rd_en)
        rdata <= addr ? BYTE_W'(mask) : (sel_svc ? BYTE_W'(isr) : BYTE_W'(irr));
      if (init_start) begin
        isr     <= '0;
        phase_q <= 1'b0;
        cas_oe  <= 1'b0;
      end else begin
        isr <= (isr & ~eoi_mask) | (svc_set ? (N_LINES'(1) << win_idx) : '0);
        if (running && ack) phase_q <= !phase_q;
        if (commit_go && !is_slave) begin
          vec_hold <= {base, idx_eff};
          own_q    <= !cascaded;
          cas_oe   <= cascaded;
          cas_out  <= win_idx;
        end
        if (running && ack && phase_q && !is_slave) begin
          vec_out   <= vec_hold;
          vec_valid <= own_q;
          cas_oe    <= 1'b0;
        end
        if (commit_go && is_slave) begin
          vec_out   <= {base, idx_eff};
          vec_valid <= 1'b1;
        end
      end
    end
  end

  // R1: no interrupt output while setup has not completed
  p_int_needs_init_r1: assert property (@(posedge clk) disable iff (rst)
    (!running && !$past(running)) |-> !int_out);

  // R7: a vector only ever follows an acknowledge pulse, and lasts one cycle
  p_vec_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack));
  p_vec_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  // R8: a specific end-of-interrupt clears the named bit
  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (eoi_go && !svc_set) |=> !isr[$past(eoi_idx)]);

  // R9: automatic mode never holds an in-service bit
  p_aeoi_isr_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (running && aeoi) |-> (isr == '0));

  // R12: a slave never drives the cascade bus
  p_slave_quiet_bus_r12: assert property (@(posedge clk) disable iff (rst)
    is_slave |-> !cas_oe);
endmodule

// File: tb/cascade_irq_ctrl_tb_top.sv
module cascade_irq_ctrl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst;
  logic       m_wr, s_wr, m_rd, s_rd, addr, ack;
  logic [7:0] wdata, m_rdata, s_rdata, m_lines, s_lines;
  logic       m_int, s_int, m_vv, s_vv, m_cas_oe, s_cas_oe;
  logic [7:0] m_vec, s_vec;
  logic [2:0] m_cas_out, s_cas_out;
  wire  [7:0] m_irq = {m_lines[7:3], s_int, m_lines[1:0]};

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cascade_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .is_slave(1'b0), .wr_en(m_wr), .rd_en(m_rd), .addr(addr),
    .wdata(wdata), .rdata(m_rdata), .irq_in(m_irq), .int_out(m_int), .ack(ack),
    .vec_out(m_vec), .vec_valid(m_vv), .cas_in(3'b000), .cas_en_in(1'b0),
    .cas_out(m_cas_out), .cas_oe(m_cas_oe)
  );

  cascade_irq_ctrl slave_i (
    .clk(clk), .rst(rst), .is_slave(1'b1), .wr_en(s_wr), .rd_en(s_rd), .addr(addr),
    .wdata(wdata), .rdata(s_rdata), .irq_in(s_lines), .int_out(s_int), .ack(ack),
    .vec_out(s_vec), .vec_valid(s_vv), .cas_in(m_cas_out), .cas_en_in(m_cas_oe),
    .cas_out(s_cas_out), .cas_oe(s_cas_oe)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit slv, input bit a, input logic [7:0] d);
    addr = a; wdata = d;
    if (slv) s_wr = 1'b1; else m_wr = 1'b1;
    tick(1);
    m_wr = 1'b0; s_wr = 1'b0;
  endtask

  task automatic rd(input bit slv, input bit a, output logic [7:0] d);
    addr = a;
    if (slv) s_rd = 1'b1; else m_rd = 1'b1;
    tick(1);
    d = slv ? s_rdata : m_rdata;
    m_rd = 1'b0; s_rd = 1'b0;
  endtask

  // first-pulse snapshot: {master vec_valid, master cas_oe, master cas_out}
  task automatic do_ack(output logic [4:0] mid, output logic mv, output logic [7:0] mvec,
                        output logic sv, output logic [7:0] svec);
    ack = 1'b1; tick(1); ack = 1'b0;
    mid = {m_vv, m_cas_oe, m_cas_out};
    tick(1);
    ack = 1'b1; tick(1); ack = 1'b0;
    mv = m_vv; mvec = m_vec; sv = s_vv; svec = s_vec;
  endtask

  logic [4:0] mid;
  logic       mv, sv;
  logic [7:0] mvec, svec, rv;

  task automatic t_reset();
    check("R1", "int after reset", {7'b0, m_int}, 8'h00);
    rd(0, 1, rv); check("R1", "mask after reset", rv, 8'hFF);
    wr(0, 1, 8'h00);
    rd(0, 1, rv); check("R1", "mask load before setup", rv, 8'h00);
    m_lines[3] = 1'b1; tick(3);
    check("R1", "int before setup", {7'b0, m_int}, 8'h00);
    rd(0, 0, rv); check("R1", "request before setup", rv, 8'h00);
    m_lines[3] = 1'b0; tick(1);
  endtask

  task automatic t_init();
    wr(0, 0, 8'h11); wr(0, 1, 8'h30); wr(0, 1, 8'h04);
    m_lines[3] = 1'b1; tick(1);
    wr(0, 1, 8'h01); tick(3);
    check("R2", "rise during setup ignored", {7'b0, m_int}, 8'h00);
    m_lines[3] = 1'b0;
    wr(1, 0, 8'h11); wr(1, 1, 8'h38); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    wr(1, 1, 8'h00); tick(1);
    m_lines[3] = 1'b1; tick(2);
    check("R2", "int after setup", {7'b0, m_int}, 8'h01);
    do_ack(mid, mv, mvec, sv, svec);
    check("R7", "no vector after first pulse", {7'b0, mid[4]}, 8'h00);
    check("R7", "vector valid", {7'b0, mv}, 8'h01);
    check("R3", "vector line 3", mvec, 8'h33);
    check("R12", "slave silent", {7'b0, sv}, 8'h00);
    m_lines[3] = 1'b0;
    wr(0, 0, 8'h63); tick(1);
  endtask

  task automatic t_priority();
    m_lines[6] = 1'b1; m_lines[1] = 1'b1; tick(2);
    do_ack(mid, mv, mvec, sv, svec);
    check("R6", "highest wins", mvec, 8'h31);
    tick(2);
    check("R6", "lower blocked by service", {7'b0, m_int}, 8'h00);
    wr(0, 0, 8'h61); tick(2);
    check("R6", "released after eoi", {7'b0, m_int}, 8'h01);
    do_ack(mid, mv, mvec, sv, svec);
    check("R6", "line 6 vector", mvec, 8'h36);
    m_lines[4] = 1'b1; tick(2);
    check("R6", "higher preempts", {7'b0, m_int}, 8'h01);
    do_ack(mid, mv, mvec, sv, svec);
    check("R6", "line 4 vector", mvec, 8'h34);
    wr(0, 0, 8'h0B);
    rd(0, 0, rv); check("R5", "nested service", rv, 8'h50);
    wr(0, 0, 8'h64); wr(0, 0, 8'h66);
    rd(0, 0, rv); check("R8", "all cleared", rv, 8'h00);
    wr(0, 0, 8'h0A);
    m_lines = 8'h00; tick(1);
  endtask

  task automatic t_mask();
    wr(0, 1, 8'h08);
    m_lines[3] = 1'b1; tick(3);
    check("R4", "masked line quiet", {7'b0, m_int}, 8'h00);
    rd(0, 1, rv); check("R4", "mask readback", rv, 8'h08);
    rd(0, 0, rv); check("R4", "request kept", rv, 8'h08);
    wr(0, 1, 8'h00); tick(2);
    check("R4", "unmasked raises", {7'b0, m_int}, 8'h01);
    do_ack(mid, mv, mvec, sv, svec);
    check("R4", "vector after unmask", mvec, 8'h33);
    wr(0, 0, 8'h63);
    m_lines = 8'h00; tick(1);
  endtask

  task automatic t_readback();
    m_lines[3] = 1'b1; tick(2);
    do_ack(mid, mv, mvec, sv, svec);
    m_lines[1] = 1'b1; tick(2);
    do_ack(mid, mv, mvec, sv, svec);
    check("R6", "nested line 1", mvec, 8'h31);
    m_lines[1] = 1'b0; m_lines[3] = 1'b0;
    m_lines[5] = 1'b1; tick(1);
    wr(0, 0, 8'h0B);
    rd(0, 0, rv); check("R5", "service select", rv, 8'h0A);
    rd(0, 0, rv); check("R5", "select persists", rv, 8'h0A);
    wr(0, 0, 8'h63);
    rd(0, 0, rv); check("R8", "only bit 3 cleared", rv, 8'h02);
    wr(0, 0, 8'h0A);
    rd(0, 0, rv); check("R5", "request select", rv, 8'h20);
    wr(0, 0, 8'h61); tick(2);
    check("R8", "int after last eoi", {7'b0, m_int}, 8'h01);
    do_ack(mid, mv, mvec, sv, svec);
    check("R3", "vector line 5", mvec, 8'h35);
    wr(0, 0, 8'h65);
    m_lines = 8'h00; tick(1);
  endtask

  task automatic t_spurious();
    wr(0, 1, 8'h80);
    m_lines[4] = 1'b1; tick(2);
    check("R10", "int raised", {7'b0, m_int}, 8'h01);
    m_lines[4] = 1'b0; tick(2);
    do_ack(mid, mv, mvec, sv, svec);
    check("R10", "spurious vector", mvec, 8'h37);
    check("R10", "spurious valid", {7'b0, mv}, 8'h01);
    wr(0, 0, 8'h0B);
    rd(0, 0, rv); check("R10", "no service bit", rv, 8'h00);
    wr(0, 0, 8'h0A);
    wr(0, 1, 8'h00); tick(1);
  endtask

  task automatic t_cascade();
    s_lines[6] = 1'b1; tick(4);
    check("R11", "slave request reaches master", {7'b0, m_int}, 8'h01);
    do_ack(mid, mv, mvec, sv, svec);
    check("R11", "cascade bus after first pulse", {3'b0, mid}, 8'h0A);
    check("R11", "master no vector", {7'b0, mv}, 8'h00);
    check("R12", "slave vector valid", {7'b0, sv}, 8'h01);
    check("R12", "slave vector", svec, 8'h3E);
    check("R11", "bus released", {7'b0, m_cas_oe}, 8'h00);
    wr(0, 0, 8'h0B); wr(1, 0, 8'h0B);
    rd(0, 0, rv); check("R11", "master service bit", rv, 8'h04);
    rd(1, 0, rv); check("R12", "slave service bit", rv, 8'h40);
    wr(1, 0, 8'h66); wr(0, 0, 8'h62);
    rd(0, 0, rv); check("R8", "master cleared", rv, 8'h00);
    rd(1, 0, rv); check("R8", "slave cleared", rv, 8'h00);
    wr(0, 0, 8'h0A); wr(1, 0, 8'h0A);
    s_lines = 8'h00; tick(2);
  endtask

  task automatic t_aeoi();
    wr(0, 0, 8'h11); wr(0, 1, 8'h30); wr(0, 1, 8'h04); wr(0, 1, 8'h03);
    m_lines[5] = 1'b1; tick(2);
    do_ack(mid, mv, mvec, sv, svec);
    check("R9", "auto mode vector", mvec, 8'h35);
    wr(0, 0, 8'h0B);
    rd(0, 0, rv); check("R9", "no service bit kept", rv, 8'h00);
    m_lines[6] = 1'b1; tick(2);
    check("R9", "lower line not blocked", {7'b0, m_int}, 8'h01);
    do_ack(mid, mv, mvec, sv, svec);
    check("R9", "line 6 vector", mvec, 8'h36);
    m_lines = 8'h00; tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; m_wr = 0; s_wr = 0; m_rd = 0; s_rd = 0; addr = 0; ack = 0;
    wdata = 8'h00; m_lines = 8'h00; s_lines = 8'h00;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_init();
    t_priority();
    t_mask();
    t_readback();
    t_spurious();
    t_cascade();
    t_aeoi();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule